// File: doc/BRIEF.md
# AES-128 Round Key Expander

This block turns a 128-bit cipher key into the eleven 128-bit round keys used by AES-128 encryption: the cipher key itself as round key 0, then ten derived keys. A pulse on `start` captures the key and resets the round index to zero. After that, every rising clock edge with `enable` high replaces the held round key with the next one and advances the index by one. The run stops once round key 10 has been produced.

The 4-bit round index is an output so that an encryption datapath can use it as its round sequencer instead of carrying a counter of its own. The datapath reads `roundKey` and `roundIdx` together and treats `done` as the end of the schedule. Each new key comes from the current one through a single combinational step. That step wires the last word into four substitution lookups in rotated byte order, mixes in a round constant from a small ROM indexed by the round, and chains XORs across the four words.

Top module: `keyexp_top`

## Requirements
- R1: After reset, `roundKey` is all zeros, `roundIdx` is 0 and `done` is 0.
- R2: One cycle after a clock edge with `start` high, `roundKey` equals the `keyIn` value present at that edge, `roundIdx` is 0 and `done` is 0.
- R3: On every clock edge with `enable` high, `start` low, a run in progress and `roundIdx` below 10, `roundIdx` rises by exactly one and `roundKey` takes the next round key at that same edge. `roundIdx` never exceeds 10.
- R4: On a clock edge with both `enable` and `start` low, `roundKey`, `roundIdx` and `done` keep their values.
- R5: With words ordered w0 = bits 127:96 through w3 = bits 31:0, the next key is n0 = w0 ^ S(rot(w3)) ^ (rc << 24), n1 = w1 ^ n0, n2 = w2 ^ n1, n3 = w3 ^ n2. Here rot moves the top byte of a word to the bottom, and S applies the AES substitution (the GF(2^8) inverse followed by the affine map with constant 0x63) to each byte. The constant rc for the step from round r to round r+1 (r = 0..9) is 01, 02, 04, 08, 10, 20, 40, 80, 1B, 36.
- R6: `done` rises at the edge that produces round key 10, which is also the edge where `roundIdx` becomes 10. While `done` is high and `start` is low, `enable` has no effect: the key, the index and `done` all hold.
- R7: `start` takes priority over `enable`. A start in the middle of a run, or after one has finished, reloads `keyIn`, sets the index to 0 and clears `done`.
- R8: Before the first `start` after reset, `enable` has no effect: `roundKey` stays all zeros and `roundIdx` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load `keyIn` as round key 0 and begin a run |
| keyIn | input | 128 | Cipher key |
| enable | input | 1 | Advance to the next round key on this edge |
| roundKey | output | 128 | Round key for the current round index |
| roundIdx | output | 4 | Current round index, 0 to 10 |
| done | output | 1 | High once round key 10 has been produced |

## Verification
A fault in the round counter shows at the ports on the very next edge. Either `roundIdx` fails to step by one, or `done` appears with the wrong index, and the round constant then applied to the following key is also wrong. A fault in the key register, the rotation wiring, the S-box or the constant ROM appears in `roundKey` on the edge it occurs and carries into every later key. The full published expansion of a known key is therefore compared round by round. The all-zero key adds a second case in which the substitution of zero and the first constants stand out on their own.

// File: rtl/keyexp_pkg.sv
package keyexp_pkg;
  localparam int KEY_W    = 128;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int N_ROUNDS = 10;
  localparam int CNT_W    = 4;

  typedef struct packed {
    logic             load;
    logic             step;
    logic [CNT_W-1:0] round;
  } ctrlStrobes_t;
endpackage

// File: rtl/keyexp_sbox.sv
module keyexp_sbox #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] inByte,
  output logic [BW-1:0] outByte
);
  localparam logic [BW-1:0] AFFINE_C = 8'h63;
  localparam logic [BW-1:0] POLY_LOW = 8'h1b;

  function automatic logic [BW-1:0] gfMul(input logic [BW-1:0] a, input logic [BW-1:0] b);
    logic [BW-1:0] acc;
    logic [BW-1:0] aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < BW; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = aa[BW-1] ? ((aa << 1) ^ POLY_LOW) : (aa << 1);
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse; zero maps to zero
  function automatic logic [BW-1:0] gfInv(input logic [BW-1:0] x);
    logic [BW-1:0] pw;
    logic [BW-1:0] acc;
    pw  = x;
    acc = 8'h01;
    for (int i = 1; i < BW; i++) begin
      pw  = gfMul(pw, pw);
      acc = gfMul(acc, pw);
    end
    return acc;
  endfunction

  function automatic logic [BW-1:0] rotl(input logic [BW-1:0] v, input int n);
    return (v << n) | (v >> (BW - n));
  endfunction

  logic [BW-1:0] invVal;

  always_comb begin
    invVal  = gfInv(inByte);
    outByte = invVal ^ rotl(invVal, 1) ^ rotl(invVal, 2) ^ rotl(invVal, 3)
              ^ rotl(invVal, 4) ^ AFFINE_C;
  end
endmodule

// File: rtl/keyexp_ctrl.sv
module keyexp_ctrl
  import keyexp_pkg::*;
#(
  parameter int ROUNDS = N_ROUNDS,
  parameter int CW     = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         enable,
  output ctrlStrobes_t strobes,
  output logic         done
);
  localparam logic [CW-1:0] LAST_IDX = CW'(ROUNDS);
  localparam logic [CW-1:0] PRE_LAST = CW'(ROUNDS - 1);

  logic [CW-1:0] roundCnt;
  logic          armed;
  logic          doStep;

  assign doStep = enable && armed && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roundCnt <= '0;
      armed    <= 1'b0;
      done     <= 1'b0;
    end else if (start) begin
      roundCnt <= '0;
      armed    <= 1'b1;
      done     <= 1'b0;
    end else if (doStep) begin
      roundCnt <= roundCnt + 1'b1;
      if (roundCnt == PRE_LAST) begin
        armed <= 1'b0;
        done  <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load  = start;
    strobes.step  = doStep;
    strobes.round = roundCnt;
  end

  logic unusedLast;
  assign unusedLast = (roundCnt == LAST_IDX);
endmodule

// File: rtl/keyexp_datapath.sv
module keyexp_datapath
  import keyexp_pkg::*;
#(
  parameter int KW = KEY_W,
  parameter int WW = WORD_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrlStrobes_t  strobes,
  input  logic [KW-1:0] keyIn,
  output logic [KW-1:0] roundKey
);
  localparam int N_WORDS = KW / WW;
  localparam int N_BYTES = WW / BW;

  logic [KW-1:0]      keyReg;
  logic [WW-1:0]      wCur  [N_WORDS];
  logic [WW-1:0]      wNext [N_WORDS];
  logic [WW-1:0]      rotWord;
  logic [WW-1:0]      subWord;
  logic [BW-1:0]      rconByte;
  logic [KW-1:0]      nextKey;

  genvar gw;
  generate
    for (gw = 0; gw < N_WORDS; gw++) begin : g_split
      assign wCur[gw] = keyReg[KW-1-gw*WW -: WW];
      assign nextKey[KW-1-gw*WW -: WW] = wNext[gw];
    end
  endgenerate

  // rotation is wiring only: top byte of the last word moves to the bottom
  assign rotWord = {wCur[N_WORDS-1][WW-BW-1:0], wCur[N_WORDS-1][WW-1 -: BW]};

  genvar gb;
  generate
    for (gb = 0; gb < N_BYTES; gb++) begin : g_sbox
      keyexp_sbox #(.BW(BW)) i_sbox (
        .inByte (rotWord[gb*BW +: BW]),
        .outByte(subWord[gb*BW +: BW])
      );
    end
  endgenerate

  // round constant ROM, read every cycle at the current round index
  always_comb begin
    unique case (strobes.round)
      4'd0:    rconByte = 8'h01;
      4'd1:    rconByte = 8'h02;
      4'd2:    rconByte = 8'h04;
      4'd3:    rconByte = 8'h08;
      4'd4:    rconByte = 8'h10;
      4'd5:    rconByte = 8'h20;
      4'd6:    rconByte = 8'h40;
      4'd7:    rconByte = 8'h80;
      4'd8:    rconByte = 8'h1b;
      4'd9:    rconByte = 8'h36;
      default: rconByte = 8'h00;
    endcase
  end

  always_comb begin
    wNext[0] = wCur[0] ^ subWord ^ {rconByte, {(WW-BW){1'b0}}};
    for (int i = 1; i < N_WORDS; i++) begin
      wNext[i] = wCur[i] ^ wNext[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             keyReg <= '0;
    else if (strobes.load)  keyReg <= keyIn;
    else if (strobes.step)  keyReg <= nextKey;
  end

  assign roundKey = keyReg;
endmodule

// File: rtl/keyexp_top.sv
module keyexp_top
  import keyexp_pkg::*;
#(
  parameter int KW = KEY_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] keyIn,
  input  logic          enable,
  output logic [KW-1:0] roundKey,
  output logic [CW-1:0] roundIdx,
  output logic          done
);
  ctrlStrobes_t strobes;

  keyexp_ctrl #(.ROUNDS(N_ROUNDS), .CW(CW)) i_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .enable (enable),
    .strobes(strobes),
    .done   (done)
  );

  keyexp_datapath #(.KW(KW), .WW(WORD_W), .BW(BYTE_W)) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .keyIn   (keyIn),
    .roundKey(roundKey)
  );

  assign roundIdx = strobes.round;
endmodule

// File: rtl/keyexp_checker.sv
module keyexp_checker #(
  parameter int KW = 128,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [KW-1:0] keyIn,
  input logic          enable,
  input logic [KW-1:0] roundKey,
  input logic [CW-1:0] roundIdx,
  input logic          done
);
  localparam logic [CW-1:0] LAST = CW'(10);

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (roundIdx == '0) && (roundKey == $past(keyIn)) && !done);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !start && roundIdx != '0 && roundIdx < LAST) |=> roundIdx == $past(roundIdx) + 1'b1);

  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    roundIdx <= LAST);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !enable) |=> $stable(roundKey) && $stable(roundIdx) && $stable(done));

  p_done_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> roundIdx == LAST);

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done && $stable(roundKey));
endmodule

bind keyexp_top keyexp_checker #(.KW(KW), .CW(CW)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .keyIn   (keyIn),
  .enable  (enable),
  .roundKey(roundKey),
  .roundIdx(roundIdx),
  .done    (done)
);

// File: tb/test_keyexp_top.sv
module test_keyexp_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] keyIn = '0;
  logic         enable = 1'b0;
  logic [127:0] roundKey;
  logic [3:0]   roundIdx;
  logic         done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [127:0] fipsKeys [11];

  always #2 clk = ~clk;

  keyexp_top i_keyexp_top (
    .clk(clk), .rst_n(rst_n), .start(start), .keyIn(keyIn),
    .enable(enable), .roundKey(roundKey), .roundIdx(roundIdx), .done(done)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, let one posedge pass, observe at the following negedge
  task automatic tick(input logic st, input logic en);
    start  = st;
    enable = en;
    @(posedge clk);
    @(negedge clk);
    start  = 1'b0;
    enable = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 key", roundKey, '0);
    chk("R1 idx", 128'(roundIdx), 128'd0);
    chk("R1 done", 128'(done), 128'd0);
  endtask

  task automatic t_enable_before_start;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    chk("R8 key", roundKey, '0);
    chk("R8 idx", 128'(roundIdx), 128'd0);
  endtask

  task automatic t_fips_run;
    keyIn = fipsKeys[0];
    tick(1'b1, 1'b0);
    chk("R2 key", roundKey, fipsKeys[0]);
    chk("R2 idx", 128'(roundIdx), 128'd0);
    chk("R2 done", 128'(done), 128'd0);
    for (int r = 1; r <= 10; r++) begin
      tick(1'b0, 1'b1);
      chk($sformatf("R5 round key %0d", r), roundKey, fipsKeys[r]);
      chk($sformatf("R3 idx %0d", r), 128'(roundIdx), 128'(r));
      chk($sformatf("R6 done at %0d", r), 128'(done), (r == 10) ? 128'd1 : 128'd0);
      if (r == 4) begin
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        chk("R4 key hold", roundKey, fipsKeys[4]);
        chk("R4 idx hold", 128'(roundIdx), 128'd4);
      end
    end
  endtask

  task automatic t_after_done;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b1);
    chk("R6 key after done", roundKey, fipsKeys[10]);
    chk("R6 idx after done", 128'(roundIdx), 128'd10);
    chk("R6 done held", 128'(done), 128'd1);
  endtask

  task automatic t_zero_key;
    keyIn = '0;
    tick(1'b1, 1'b0);
    chk("R7 done cleared", 128'(done), 128'd0);
    chk("R7 key reload", roundKey, '0);
    tick(1'b0, 1'b1);
    chk("R5 zero key r1", roundKey, 128'h62636363626363636263636362636363);
    tick(1'b0, 1'b1);
    chk("R5 zero key r2", roundKey, 128'h9b9898c9f9fbfbaa9b9898c9f9fbfbaa);
  endtask

  task automatic t_start_over_enable;
    keyIn = fipsKeys[0];
    tick(1'b1, 1'b1);
    chk("R7 start wins key", roundKey, fipsKeys[0]);
    chk("R7 start wins idx", 128'(roundIdx), 128'd0);
    tick(1'b0, 1'b1);
    chk("R7 run after restart", roundKey, fipsKeys[1]);
  endtask

  initial begin
    fipsKeys[0]  = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    fipsKeys[1]  = 128'ha0fafe1788542cb123a339392a6c7605;
    fipsKeys[2]  = 128'hf2c295f27a96b9435935807a7359f67f;
    fipsKeys[3]  = 128'h3d80477d4716fe3e1e237e446d7a883b;
    fipsKeys[4]  = 128'hef44a541a8525b7fb671253bdb0bad00;
    fipsKeys[5]  = 128'hd4d1c6f87c839d87caf2b8bc11f915bc;
    fipsKeys[6]  = 128'h6d88a37a110b3efddbf98641ca0093fd;
    fipsKeys[7]  = 128'h4e54f70e5f5fc9f384a64fb24ea6dc4f;
    fipsKeys[8]  = 128'head27321b58dbad2312bf5607f8d292f;
    fipsKeys[9]  = 128'hac7766f319fadc2128d12941575c006e;
    fipsKeys[10] = 128'hd014f9a8c9ee2589e13f0cc8b6630ca6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_before_start();
    t_fips_run();
    t_after_done();
    t_zero_key();
    t_start_over_enable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule